// File: doc/BRIEF.md
# Rounding and Symmetric Saturation Node

This block sits at an internal node of a fixed-point recursive ladder filter. It reduces a wide two's-complement sum to a narrower word. First it drops fractional bits, and then it clamps the result to a range that is symmetric about zero. Both the input and the output formats are parameters, each given as a count of integer bits (sign excluded) and a count of fractional bits.

A mode input selects one of two reductions:

- **Round-toward-zero path.** Used in front of the limiter. The value is floored to one fractional bit more than the target. If that intermediate equals minus one step, it is forced to zero. The guard bit is then dropped.
- **Plain truncation path.** Used at a post-multiplier quantization point. It discards the low bits, which rounds toward minus infinity.

The limiter judges overflow from the integer field alone, so the compare stays short. It also replaces the most negative output code with its symmetric neighbour. An optional output register carries data and a valid strobe with the same latency.

Top module: `qnode_sat`

## Requirements
- R1: While reset is held and after its release with no valid input, out_valid is 0 and out_data is 0.
- R2: With trunc_mode = 0, the result is q = floor(t/2), where t is the input floored to OUT_FRAC+1 fractional bits, with t replaced by 0 when t = -1.
- R3: With trunc_mode = 1, the result is the input floored to OUT_FRAC fractional bits, discarding the low bits.
- R4: A reduced value above the largest positive code (sign 0, all other bits 1, i.e. 2^(OUT_W-1)-1 in LSBs) is output as that code.
- R5: A reduced value below -(2^(OUT_W-1)-1) LSBs, including exactly the most negative code, is output as -(2^(OUT_W-1)-1); the code with sign 1 and all other bits 0 never appears.
- R6: An input whose value floors to minus half an output LSB gives 0 with trunc_mode = 0 and gives -1 LSB with trunc_mode = 1.
- R7: A reduced value inside the symmetric range leaves the limiter unchanged.
- R8: With REG_OUT = 1, out_data and out_valid follow in_data and in_valid after exactly one rising clock edge; with REG_OUT = 0 they follow in the same cycle.
- R9: With REG_OUT = 1, a cycle with in_valid = 0 gives out_valid = 0 at the next edge and leaves out_data at its previous value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Input sample strobe |
| trunc_mode | input | 1 | 0 = round toward zero with guard bit, 1 = plain truncation |
| in_data | input | 1+IN_INT+IN_FRAC | Wide signed input sum |
| out_valid | output | 1 | Output sample strobe |
| out_data | output | 1+OUT_INT+OUT_FRAC | Rounded and limited signed result |

## Verification
The bench uses the registered variant, where each result is due one rising edge after the input is presented. Inputs are driven on a falling edge, and the output is sampled on the following falling edge, after exactly one rising edge has passed.

The hold check places a cycle with the strobe low, carrying new data, between two samples. It reads the output one edge later and expects the earlier result.

The checker compares out_valid and out_data against the values one edge back. The combinational assertions relate the limiter's result to the input in the same cycle.

// File: rtl/qnode_pkg.sv
package qnode_pkg;

  typedef enum logic {
    QM_ROUND_ZERO = 1'b0,
    QM_TRUNC      = 1'b1
  } qmode_e;

  function automatic int qn_width(input int int_bits, input int frac_bits);
    return 1 + int_bits + frac_bits;
  endfunction

endpackage

// File: rtl/qnode_round.sv
module qnode_round
  import qnode_pkg::*;
#(
  parameter int IN_INT   = 1,
  parameter int IN_FRAC  = 15,
  parameter int OUT_FRAC = 10
) (
  input  logic [1+IN_INT+IN_FRAC-1:0]  din,
  input  qmode_e                        mode,
  output logic [1+IN_INT+OUT_FRAC-1:0] dout,
  output logic                          zero_forced
);
  localparam int IN_W = qn_width(IN_INT, IN_FRAC);
  localparam int SH   = IN_FRAC - OUT_FRAC;   // must be at least 1
  localparam int R_W  = IN_W - SH;
  localparam int G_W  = R_W + 1;

  // floor to one extra fractional bit: a plain slice of the top bits
  function automatic logic [G_W-1:0] guard_floor(input logic [IN_W-1:0] x);
    return x[IN_W-1:SH-1];
  endfunction

  // floor to the target fractional width
  function automatic logic [R_W-1:0] trunc_floor(input logic [IN_W-1:0] x);
    return x[IN_W-1:SH];
  endfunction

  logic [G_W-1:0] g;
  logic           neg_half_step;

  always_comb begin
    g             = guard_floor(din);
    neg_half_step = &g;   // value is exactly -2^-(OUT_FRAC+1)
    zero_forced   = (mode == QM_ROUND_ZERO) && neg_half_step;
    if (mode == QM_TRUNC) begin
      dout = trunc_floor(din);
    end else if (zero_forced) begin
      dout = '0;
    end else begin
      dout = g[G_W-1:1];
    end
  end
endmodule

// File: rtl/qnode_limit.sv
module qnode_limit
  import qnode_pkg::*;
#(
  parameter int RI       = 1,   // integer bits of the rounded value
  parameter int OUT_INT  = 1,
  parameter int OUT_FRAC = 10
) (
  input  logic [1+RI+OUT_FRAC-1:0]      din,
  output logic [1+OUT_INT+OUT_FRAC-1:0] dout,
  output logic                          sat_pos,
  output logic                          sat_neg
);
  localparam int R_W  = qn_width(RI, OUT_FRAC);
  localparam int O_W  = qn_width(OUT_INT, OUT_FRAC);
  localparam int HI_W = R_W - O_W + 1;

  function automatic logic [O_W-1:0] max_code();
    return {1'b0, {(O_W-1){1'b1}}};
  endfunction

  function automatic logic [O_W-1:0] min_sym_code();
    return ~max_code() + {{(O_W-1){1'b0}}, 1'b1};
  endfunction

  logic [HI_W-1:0] hi;
  logic [O_W-2:0]  lo;
  logic            pos_ovf, neg_ovf, min_hit;

  always_comb begin
    hi      = din[R_W-1:O_W-1];   // sign, dropped integer bits, output sign
    lo      = din[O_W-2:0];
    pos_ovf = !hi[HI_W-1] && (|hi);
    neg_ovf = hi[HI_W-1] && !(&hi);
    min_hit = (&hi) && !(|lo);
    sat_pos = pos_ovf;
    sat_neg = neg_ovf || min_hit;
    if (sat_pos)      dout = max_code();
    else if (sat_neg) dout = min_sym_code();
    else              dout = din[O_W-1:0];
  end
endmodule

// File: rtl/qnode_stage.sv
module qnode_stage #(
  parameter int W   = 12,
  parameter bit REG = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         vin,
  input  logic [W-1:0] din,
  output logic         vout,
  output logic [W-1:0] dout
);
  generate
    if (REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          vout <= 1'b0;
          dout <= '0;
        end else begin
          vout <= vin;
          if (vin) dout <= din;
        end
      end
    end else begin : g_comb
      assign vout = vin;
      assign dout = din;
    end
  endgenerate
endmodule

// File: rtl/qnode_sat.sv
module qnode_sat
  import qnode_pkg::*;
#(
  parameter int IN_INT   = 1,
  parameter int IN_FRAC  = 15,
  parameter int OUT_INT  = 1,
  parameter int OUT_FRAC = 10,
  parameter bit REG_OUT  = 1'b1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          in_valid,
  input  logic                          trunc_mode,
  input  logic [1+IN_INT+IN_FRAC-1:0]   in_data,
  output logic                          out_valid,
  output logic [1+OUT_INT+OUT_FRAC-1:0] out_data
);
  localparam int IN_W  = qn_width(IN_INT, IN_FRAC);
  localparam int R_W   = qn_width(IN_INT, OUT_FRAC);
  localparam int OUT_W = qn_width(OUT_INT, OUT_FRAC);

  // named internal events, visible to the bound checker
  qmode_e           mode_sel;
  logic [R_W-1:0]   rnd_data;
  logic             zero_forced;
  logic             sat_pos;
  logic             sat_neg;
  logic [OUT_W-1:0] lim_data;

  assign mode_sel = qmode_e'(trunc_mode);

  qnode_round #(
    .IN_INT  (IN_INT),
    .IN_FRAC (IN_FRAC),
    .OUT_FRAC(OUT_FRAC)
  ) u_round (
    .din        (in_data),
    .mode       (mode_sel),
    .dout       (rnd_data),
    .zero_forced(zero_forced)
  );

  qnode_limit #(
    .RI      (IN_INT),
    .OUT_INT (OUT_INT),
    .OUT_FRAC(OUT_FRAC)
  ) u_limit (
    .din    (rnd_data),
    .dout   (lim_data),
    .sat_pos(sat_pos),
    .sat_neg(sat_neg)
  );

  qnode_stage #(
    .W  (OUT_W),
    .REG(REG_OUT)
  ) u_stage (
    .clk  (clk),
    .rst_n(rst_n),
    .vin  (in_valid),
    .din  (lim_data),
    .vout (out_valid),
    .dout (out_data)
  );
endmodule

// File: rtl/qnode_sat_chk.sv
module qnode_sat_chk #(
  parameter int IN_W    = 17,
  parameter int OUT_W   = 12,
  parameter bit REG_OUT = 1'b1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             trunc_mode,
  input logic [IN_W-1:0]  in_data,
  input logic             zero_forced,
  input logic             sat_pos,
  input logic             sat_neg,
  input logic [OUT_W-1:0] lim_data,
  input logic             out_valid,
  input logic [OUT_W-1:0] out_data
);
  localparam logic [OUT_W-1:0] MIN_CODE = {1'b1, {(OUT_W-1){1'b0}}};

  a_r5_no_min_code: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> lim_data != MIN_CODE);

  a_r4_pos_from_nonneg: assert property (@(posedge clk) disable iff (!rst_n)
    sat_pos |-> !in_data[IN_W-1]);

  a_r5_neg_from_neg: assert property (@(posedge clk) disable iff (!rst_n)
    sat_neg |-> in_data[IN_W-1]);

  a_r7_sat_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(sat_pos && sat_neg));

  a_r6_zero_only_rounding: assert property (@(posedge clk) disable iff (!rst_n)
    zero_forced |-> (!trunc_mode && in_data[IN_W-1] && lim_data == '0));

  a_r2_sign_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (lim_data != '0) |-> (lim_data[OUT_W-1] == in_data[IN_W-1]));

  generate
    if (REG_OUT) begin : g_reg_chk
      a_r8_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == $past(in_valid));
      a_r8_data_latency: assert property (@(posedge clk) disable iff (!rst_n)
        $past(in_valid) |-> out_data == $past(lim_data));
      a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(in_valid) |-> $stable(out_data));
    end else begin : g_comb_chk
      a_r8_valid_direct: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == in_valid);
    end
  endgenerate
endmodule

bind qnode_sat qnode_sat_chk #(
  .IN_W   (IN_W),
  .OUT_W  (OUT_W),
  .REG_OUT(REG_OUT)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .trunc_mode (trunc_mode),
  .in_data    (in_data),
  .zero_forced(zero_forced),
  .sat_pos    (sat_pos),
  .sat_neg    (sat_neg),
  .lim_data   (lim_data),
  .out_valid  (out_valid),
  .out_data   (out_data)
);

// File: tb/test_qnode_sat.sv
module test_qnode_sat;
  localparam int II  = 2;
  localparam int IFR = 5;
  localparam int OI  = 0;
  localparam int OFR = 3;
  localparam int IW  = 1 + II + IFR;
  localparam int OW  = 1 + OI + OFR;
  localparam int MAXQ = (1 << (OW - 1)) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          trunc_mode = 1'b0;
  logic [IW-1:0] in_data = '0;
  logic          out_valid;
  logic [OW-1:0] out_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  qnode_sat #(
    .IN_INT  (II),
    .IN_FRAC (IFR),
    .OUT_INT (OI),
    .OUT_FRAC(OFR),
    .REG_OUT (1'b1)
  ) i_qnode_sat (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .trunc_mode(trunc_mode),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_data  (out_data)
  );

  function automatic int floor_div(input int a, input int b);
    if (a >= 0) return a / b;
    return -((-a + b - 1) / b);
  endfunction

  // reference: reduce, then clamp to the symmetric range
  function automatic int ref_q(input int x, input bit trunc);
    int step;
    int t;
    int q;
    step = 1 << (IFR - OFR);
    if (trunc) begin
      q = floor_div(x, step);
    end else begin
      t = floor_div(x, step / 2);
      if (t == -1) t = 0;
      q = floor_div(t, 2);
    end
    if (q > MAXQ) q = MAXQ;
    if (q < -MAXQ) q = -MAXQ;
    return q;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // drive on a falling edge, read one rising edge later
  task automatic apply(input int x, input bit trunc, input string req, input int exp);
    int act;
    @(negedge clk);
    in_data    = x[IW-1:0];
    trunc_mode = trunc;
    in_valid   = 1'b1;
    @(negedge clk);
    act = $signed(out_data);
    check(req, act, exp);
    check("R8", int'(out_valid), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", int'(out_valid), 0);
    check("R1", int'(out_data), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", int'(out_valid), 0);

    // corners
    apply(127, 1'b0, "R4", 7);
    apply(32, 1'b0, "R4", 7);
    apply(32, 1'b1, "R4", 7);
    apply(-128, 1'b0, "R5", -7);
    apply(-32, 1'b0, "R5", -7);
    apply(-32, 1'b1, "R5", -7);
    apply(-2, 1'b0, "R6", 0);
    apply(-2, 1'b1, "R6", -1);
    apply(-1, 1'b0, "R6", 0);
    apply(20, 1'b0, "R7", 5);
    apply(-20, 1'b0, "R7", -5);
    apply(-21, 1'b0, "R2", -6);
    apply(-21, 1'b1, "R3", -6);
    apply(-3, 1'b0, "R2", -1);

    // hold when the strobe is low
    apply(20, 1'b0, "R9", 5);
    in_valid = 1'b0;
    in_data  = 8'h9c;
    @(negedge clk);
    check("R9", int'(out_valid), 0);
    check("R9", $signed(out_data), 5);

    // exhaustive sweep in both modes
    for (int v = -128; v < 128; v++) apply(v, 1'b0, "R2", ref_q(v, 1'b0));
    for (int v = -128; v < 128; v++) apply(v, 1'b1, "R3", ref_q(v, 1'b1));

    in_valid = 1'b0;
    @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule